// File: doc/BRIEF.md
# Hibernate Alarm Wake Controller

This block lives in the always-on clock domain. It compares a free-running time-of-year count against a programmable alarm value. When the two become equal while the alarm enable is set, it records a sticky wake cause. The recorded cause drives an open-drain wake pin through a drive-low enable. Because the pin is only ever pulled low, several wake sources sharing one external pull-up combine as a wired NOR.

The same block tracks the hibernate state. A firewall request (active low) that is seen while main power-good is high latches the hibernate flag. The flag holds while the main supply is down and the request stays asserted, and it drops when the request is released. A rising edge of main power-good is a hibernate wakeup if the firewall request was sampled asserted just before that edge. Tying the request to power-good is one such case. A hibernate wakeup gives a one-cycle indication to the boot logic, which then resets the main domain but keeps the time-of-year count. Any other rise of power-good is a cold boot.

The firewall and power-good inputs come from other domains and pass through synchronizers of `SYNC_STAGES` flops, which default to 2. A qualify input gates the pin so that the undefined state after battery reinsertion cannot wake the system. All pins are plain level control and status. The block carries no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `hib_wake_ctrl`

## Requirements
- R1: While `rst_n` is low, `wake_cause`, `hibernating`, `hib_wakeup` and `wake_pull_low` are all 0.
- R2: `wake_cause` becomes 1 on the clock edge after the cycle in which `toy_count == alarm_cmp` starts to hold while `alarm_en` is 1. Equality while `alarm_en` is 0 does not set it.
- R3: Once set, `wake_cause` stays 1 until a cycle with `cause_clr` = 1. It then reads 0 after that edge.
- R4: Equality that continues over several cycles sets the cause only once. After a clear, `wake_cause` stays 0 while the same equality persists.
- R5: When a new equality and `cause_clr` arrive in the same cycle, `wake_cause` is 1 after the edge.
- R6: `wake_pull_low` is 1 exactly when `wake_cause` is 1 and `wake_qual` is 1, in the same cycle. The pin is never driven high.
- R7: While `wake_qual` is 0, `wake_pull_low` is 0 even though `wake_cause` is 1.
- R8: `hibernating` becomes 1 three edges (SYNC_STAGES+1) after `fw_req_n` = 0 is applied while `main_pgood` = 1. It stays 1 while `fw_req_n` stays 0, including while `main_pgood` is 0. It drops three edges after `fw_req_n` returns to 1.
- R9: `hib_wakeup` pulses for exactly one cycle, three edges after `main_pgood` rises, if `fw_req_n` was 0 in the cycle before the rise. If `fw_req_n` was 1 (cold boot), it stays 0.
- R10: If `fw_req_n` is driven equal to `main_pgood`, every rise of `main_pgood` produces a `hib_wakeup` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Always-on asynchronous reset, active low |
| toy_count | input | TOY_W | Free-running time-of-year count |
| alarm_cmp | input | TOY_W | Alarm compare value |
| alarm_en | input | 1 | Hibernate alarm enable |
| fw_req_n | input | 1 | Firewall / hibernate request, active low, asynchronous |
| main_pgood | input | 1 | Main-domain power-good, asynchronous |
| cause_clr | input | 1 | Software strobe that clears the wake cause |
| wake_qual | input | 1 | Qualifier that gates the wake pin |
| wake_pull_low | output | 1 | Drive-low enable for the open-drain wake pin |
| wake_cause | output | 1 | Sticky alarm wake cause |
| hibernating | output | 1 | Latched hibernate flag |
| hib_wakeup | output | 1 | One-cycle hibernate wakeup indication for boot logic |

## Verification
The bench targets the cycle where a new match and a clear collide. A design that lets the clear win loses the alarm entirely. It also holds the equality after a clear. A level-sensitive compare would re-raise the cause at once and pull the pin low forever.

The tied request/power-good case is the subtle wakeup. A design that samples the request after the rise sees it released and treats every boot as cold, resetting the time of day. The bench also drops power-good during hibernate and lowers the qualifier while a cause is pending. A flag that clears on power loss, or a pin that ignores the qualifier, fails there.

// File: rtl/hwk_pkg.sv
package hwk_pkg;
  localparam int unsigned DEF_TOY_W  = 32;
  localparam int unsigned DEF_SYNC_N = 2;

  typedef enum logic {
    FW_ON  = 1'b0,
    FW_OFF = 1'b1
  } fw_lvl_e;
endpackage

// File: rtl/hwk_sync.sv
module hwk_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain[0] <= d_async;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hwk_alarm.sv
module hwk_alarm #(
  parameter int unsigned TOY_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOY_W-1:0] toy_count,
  input  logic [TOY_W-1:0] alarm_cmp,
  input  logic             alarm_en,
  input  logic             cause_clr,
  output logic             cause_q
);
  logic hit, hit_prev, hit_new;

  assign hit     = alarm_en && (toy_count == alarm_cmp);
  assign hit_new = hit && !hit_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_prev <= 1'b0;
      cause_q  <= 1'b0;
    end else begin
      hit_prev <= hit;
      // a fresh match outranks a clear in the same cycle
      if (hit_new)        cause_q <= 1'b1;
      else if (cause_clr) cause_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hwk_hib.sv
module hwk_hib
  import hwk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fw_s,
  input  logic pg_s,
  output logic hib_q,
  output logic wake_q
);
  logic fw_d, pg_d, pg_rise;

  assign pg_rise = pg_s && !pg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fw_d   <= FW_OFF;
      pg_d   <= 1'b0;
      hib_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      fw_d   <= fw_s;
      pg_d   <= pg_s;
      // fw_d is the request level from the sample before the rise
      wake_q <= pg_rise && (fw_d == FW_ON);
      if (fw_s == FW_OFF)   hib_q <= 1'b0;
      else if (pg_s)        hib_q <= 1'b1;
    end
  end
endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl #(
  parameter int unsigned TOY_W       = hwk_pkg::DEF_TOY_W,
  parameter int unsigned SYNC_STAGES = hwk_pkg::DEF_SYNC_N
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOY_W-1:0] toy_count,
  input  logic [TOY_W-1:0] alarm_cmp,
  input  logic             alarm_en,
  input  logic             fw_req_n,
  input  logic             main_pgood,
  input  logic             cause_clr,
  input  logic             wake_qual,
  output logic             wake_pull_low,
  output logic             wake_cause,
  output logic             hibernating,
  output logic             hib_wakeup
);
  logic fw_s, pg_s;

  hwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_fw_sync (
    .clk(clk), .rst_n(rst_n), .d_async(fw_req_n), .q_sync(fw_s));

  hwk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d_async(main_pgood), .q_sync(pg_s));

  hwk_hib u_hib (
    .clk(clk), .rst_n(rst_n), .fw_s(fw_s), .pg_s(pg_s),
    .hib_q(hibernating), .wake_q(hib_wakeup));

  hwk_alarm #(.TOY_W(TOY_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .toy_count(toy_count), .alarm_cmp(alarm_cmp),
    .alarm_en(alarm_en), .cause_clr(cause_clr), .cause_q(wake_cause));

  assign wake_pull_low = wake_cause && wake_qual;
endmodule

// File: rtl/hib_wake_ctrl_chk.sv
module hib_wake_ctrl_chk #(
  parameter int unsigned TOY_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [TOY_W-1:0] toy_count,
  input logic [TOY_W-1:0] alarm_cmp,
  input logic             alarm_en,
  input logic             cause_clr,
  input logic             wake_qual,
  input logic             wake_pull_low,
  input logic             wake_cause,
  input logic             hibernating,
  input logic             hib_wakeup
);
  logic eq;
  assign eq = alarm_en && (toy_count == alarm_cmp);

  assert_reset_clean_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!wake_cause && !hibernating && !hib_wakeup));

  assert_cause_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_cause) |-> $past(eq));

  assert_cause_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_cause && !cause_clr) |=> wake_cause);

  assert_cause_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_clr && !eq) |=> !wake_cause);

  assert_match_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eq) && cause_clr) |=> wake_cause);

  assert_pin_needs_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pull_low |-> wake_cause);

  assert_qual_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_qual |-> !wake_pull_low);

  assert_wake_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hib_wakeup |=> !hib_wakeup);
endmodule

bind hib_wake_ctrl hib_wake_ctrl_chk #(.TOY_W(TOY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .toy_count(toy_count), .alarm_cmp(alarm_cmp),
  .alarm_en(alarm_en), .cause_clr(cause_clr), .wake_qual(wake_qual),
  .wake_pull_low(wake_pull_low), .wake_cause(wake_cause),
  .hibernating(hibernating), .hib_wakeup(hib_wakeup));

// File: tb/hib_wake_ctrl_bench.sv
module hib_wake_ctrl_bench;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] toy_count = '0, alarm_cmp = 8'hFF;
  logic          alarm_en = 1'b0, fw_req_n = 1'b1, main_pgood = 1'b0;
  logic          cause_clr = 1'b0, wake_qual = 1'b1;
  logic          wake_pull_low, wake_cause, hibernating, hib_wakeup;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hib_wake_ctrl #(.TOY_W(TW), .SYNC_STAGES(2)) u_hib_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .toy_count(toy_count), .alarm_cmp(alarm_cmp),
    .alarm_en(alarm_en), .fw_req_n(fw_req_n), .main_pgood(main_pgood),
    .cause_clr(cause_clr), .wake_qual(wake_qual), .wake_pull_low(wake_pull_low),
    .wake_cause(wake_cause), .hibernating(hibernating), .hib_wakeup(hib_wakeup));

  // expected-state model built from the requirements
  logic m_fw1, m_fw2, m_fw3, m_pg1, m_pg2, m_pg3;
  logic m_hib, m_wk, m_cause, m_hitp;

  function automatic logic exp_hit();
    return alarm_en && (toy_count == alarm_cmp);
  endfunction

  task automatic model_edge();
    logic h;
    if (!rst_n) begin
      m_fw1 = 1; m_fw2 = 1; m_fw3 = 1; m_pg1 = 0; m_pg2 = 0; m_pg3 = 0;
      m_hib = 0; m_wk = 0; m_cause = 0; m_hitp = 0;
    end else begin
      h = exp_hit();
      m_wk = m_pg2 && !m_pg3 && !m_fw3;
      if (m_fw2) m_hib = 0; else if (m_pg2) m_hib = 1;
      m_cause = (h && !m_hitp) || (m_cause && !cause_clr);
      m_hitp = h;
      m_fw3 = m_fw2; m_fw2 = m_fw1; m_fw1 = fw_req_n;
      m_pg3 = m_pg2; m_pg2 = m_pg1; m_pg1 = main_pgood;
    end
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R2/R3 wake_cause", wake_cause, m_cause);
    chk("R8 hibernating", hibernating, m_hib);
    chk("R9 hib_wakeup", hib_wakeup, m_wk);
    chk("R6 wake_pull_low", wake_pull_low, m_cause && wake_qual);
  endtask

  // inputs are set at a negedge; each cycle checks, then crosses one posedge
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      #1 cmp_model();
      @(posedge clk); model_edge();
      @(negedge clk);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_edge();
    @(negedge clk);
    run(3);
    chk("R1 cause in reset", wake_cause, 1'b0);
    chk("R1 hib in reset", hibernating, 1'b0);
    chk("R1 pin in reset", wake_pull_low, 1'b0);
    chk("R1 wakeup in reset", hib_wakeup, 1'b0);
    rst_n = 1'b1;
    run(2);

    // R2: equality with enable off does nothing
    toy_count = 8'h10; alarm_cmp = 8'h10; alarm_en = 1'b0;
    run(2);
    chk("R2 disabled match", wake_cause, 1'b0);
    // R2: enabled equality sets cause one edge later
    toy_count = 8'h0F; alarm_en = 1'b1; run(1);
    toy_count = 8'h10; run(1);
    chk("R2 match sets cause", wake_cause, 1'b1);
    chk("R6 pin low enable", wake_pull_low, 1'b1);
    // R7: qualifier blocks the pin
    wake_qual = 1'b0; #1;
    chk("R7 qual low blocks pin", wake_pull_low, 1'b0);
    wake_qual = 1'b1;
    // R4: clear during continuing equality, no retrigger
    cause_clr = 1'b1; run(1); cause_clr = 1'b0;
    chk("R3 clear drops cause", wake_cause, 1'b0);
    run(4);
    chk("R4 no retrigger", wake_cause, 1'b0);
    // R5: new match and clear in same cycle
    toy_count = 8'h11; run(1);
    toy_count = 8'h10; cause_clr = 1'b1; run(1); cause_clr = 1'b0;
    chk("R5 match beats clear", wake_cause, 1'b1);
    run(3);
    chk("R3 cause sticky", wake_cause, 1'b1);
    cause_clr = 1'b1; toy_count = 8'h20; run(1); cause_clr = 1'b0;

    // R8: enter hibernate with power up, survive power loss, exit on release
    main_pgood = 1'b1; run(4);
    fw_req_n = 1'b0; run(3);
    chk("R8 hib entry", hibernating, 1'b1);
    main_pgood = 1'b0; run(5);
    chk("R8 hib holds pg low", hibernating, 1'b1);
    // R9: power returns with request held -> wakeup pulse
    main_pgood = 1'b1; run(3);
    chk("R9 wakeup pulse", hib_wakeup, 1'b1);
    run(1);
    chk("R9 pulse one cycle", hib_wakeup, 1'b0);
    fw_req_n = 1'b1; run(3);
    chk("R8 hib exit", hibernating, 1'b0);
    // R9: cold boot
    main_pgood = 1'b0; run(4);
    main_pgood = 1'b1; run(3);
    chk("R9 cold boot no pulse", hib_wakeup, 1'b0);
    // R10: request tied to power-good
    main_pgood = 1'b0; fw_req_n = 1'b0; run(5);
    main_pgood = 1'b1; fw_req_n = 1'b1; run(3);
    chk("R10 tied wakeup", hib_wakeup, 1'b1);
    chk("R10 tied no hib flag", hibernating, 1'b0);
    run(2);

    // constrained random traffic checked every cycle against the model
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) toy_count = toy_count + 1'b1;
      if ($urandom_range(15) == 0) alarm_cmp = toy_count + TW'($urandom_range(3));
      alarm_en   = ($urandom_range(7) != 0);
      cause_clr  = ($urandom_range(9) == 0);
      wake_qual  = ($urandom_range(7) != 0);
      if ($urandom_range(19) == 0) main_pgood = ~main_pgood;
      if ($urandom_range(19) == 0) fw_req_n = ~fw_req_n;
      if ($urandom_range(199) == 0) begin
        fw_req_n = main_pgood;
      end
      run(1);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule